// File: doc/BRIEF.md
# Operand remap configuration unit

This unit receives a 32-bit remap-setup instruction word and keeps the per-operand shape assignment that the following scalar instructions use. There are five operand slots: three sources and two results (a primary result and a secondary one, which is an effective address or a store source). For each slot the unit reports whether remapping is active. When it is, the unit also reports which of four shape descriptors (0 to 3) the operand fetch or writeback logic must apply.

A setup word is recognised by a match on its primary and extended opcode fields with all reserved bits clear. Any other word is ignored. A held configuration is either one-shot or persistent. A one-shot configuration is consumed by the next completed instruction. A persistent configuration stays until a new setup replaces it or a vector-length setup cancels it. A setup whose enable mask is zero acts as an explicit disable.

Top module: `opnd_remap_cfg`

## Requirements
- R1: A word is accepted only in a cycle with `setupValid` high, `setupWord[31:26]` equal to `PRIMARY_OPC`, `setupWord[5:0]` equal to `EXT_OPC` and `setupWord[9:6]` all zero. The fields it holds drive the outputs from the cycle after the accepting clock edge.
- R2: Enable mask bits map to slots as follows: `setupWord[25]` to `srcEn[0]`, `[24]` to `srcEn[1]`, `[23]` to `srcEn[2]`, `[22]` to `dstEn[0]` and `[21]` to `dstEn[1]`.
- R3: Shape selectors map as follows: `setupWord[20:19]` to `srcSel[1:0]`, `[18:17]` to `srcSel[3:2]`, `[16:15]` to `srcSel[5:4]`, `[14:13]` to `dstSel[1:0]` and `[12:11]` to `dstSel[3:2]`.
- R4: A slot whose enable bit is 0 reports its selector as 0, whatever value the word carried.
- R5: With `setupWord[10]` clear, the configuration holds through idle cycles. All enables read 0 from the cycle after the first `instDone` pulse.
- R6: With `setupWord[10]` set, `instDone` has no effect on the outputs.
- R7: A `vlSetup` pulse clears all enables and selectors in either mode.
- R8: An accepted word replaces every held field. It takes priority over `instDone` and `vlSetup` in the same cycle.
- R9: A word that fails the opcode or reserved-bit match, or that arrives with `setupValid` low, leaves the outputs unchanged.
- R10: An accepted word whose mask `setupWord[25:21]` is zero clears all enables and selectors.
- R11: After reset, all enables and selectors are 0.
- R12: A mask of all ones (31) enables all five slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| setupValid | input | 1 | Marks `setupWord` as a candidate setup instruction |
| setupWord | input | 32 | Instruction word, field 0 at the most significant bit |
| instDone | input | 1 | A later instruction has completed |
| vlSetup | input | 1 | A vector-length setup has occurred |
| srcEn | output | 3 | Remap active per source slot |
| srcSel | output | 6 | Shape descriptor per source slot, 2 bits each |
| dstEn | output | 2 | Remap active per result slot |
| dstSel | output | 4 | Shape descriptor per result slot, 2 bits each |

## Verification
The assertions assume that the inputs carry known values in every cycle and that they stay quiet while reset is held. Each strobe is also taken as a single-cycle event that the unit samples once per clock edge. The bench meets these conditions: it holds every input at zero during reset and changes inputs only on the falling edge. It keeps each strobe high for exactly one rising edge, then returns all inputs to zero before it reads the outputs. The bench makes coincident strobes only on purpose, to exercise the priority rules.

// File: rtl/remap_cfg_pkg.sv
`timescale 1ns/1ps
package remap_cfg_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;   // capture decoded fields
    logic drop;   // clear held fields
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_STICKY  = 2'd2
  } remapMode_e;

endpackage

// File: rtl/remap_word_decode.sv
`timescale 1ns/1ps
module remap_word_decode #(
  parameter logic [5:0] PRIMARY_OPC = 6'd22,
  parameter logic [5:0] EXT_OPC     = 6'd57,
  parameter int SLOT_CNT = 5,
  parameter int SEL_W    = 2
) (
  input  logic [31:0]               word,
  input  logic                      valid,
  output logic                      accept,
  output logic [SLOT_CNT-1:0]       maskOut,
  output logic [SLOT_CNT*SEL_W-1:0] selOut,
  output logic                      persistOut
);
  // Field layout counted from the MSB (big-endian numbering)
  localparam int OPC_W    = 6;
  localparam int MASK_MSB = 31 - OPC_W;
  localparam int SEL_MSB  = MASK_MSB - SLOT_CNT;
  localparam int PST_BIT  = SEL_MSB - SLOT_CNT*SEL_W;
  localparam int RSV_MSB  = PST_BIT - 1;
  localparam int RSV_LSB  = OPC_W;

  logic opcMatch;
  logic rsvClear;

  assign opcMatch   = (word[31 -: OPC_W] == PRIMARY_OPC) && (word[OPC_W-1:0] == EXT_OPC);
  assign rsvClear   = (word[RSV_MSB:RSV_LSB] == '0);
  assign accept     = valid && opcMatch && rsvClear;
  assign persistOut = word[PST_BIT];

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_slot
    assign maskOut[k] = word[MASK_MSB - k];
    assign selOut[k*SEL_W +: SEL_W] = word[SEL_MSB - k*SEL_W -: SEL_W];
  end

endmodule

// File: rtl/remap_ctrl.sv
`timescale 1ns/1ps
module remap_ctrl
  import remap_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       maskZero,
  input  logic       persistIn,
  input  logic       instDone,
  input  logic       vlSetup,
  output cfgStrobe_t strobe,
  output logic       active
);
  remapMode_e modeQ, modeD;

  always_comb begin
    strobe.load = accept && !maskZero;
    strobe.drop = 1'b0;
    modeD       = modeQ;
    if (accept) begin
      if (maskZero) begin
        strobe.drop = 1'b1;
        modeD       = MODE_IDLE;
      end else begin
        modeD = persistIn ? MODE_STICKY : MODE_ONESHOT;
      end
    end else if (vlSetup) begin
      strobe.drop = 1'b1;
      modeD       = MODE_IDLE;
    end else if (instDone && modeQ == MODE_ONESHOT) begin
      strobe.drop = 1'b1;
      modeD       = MODE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_IDLE;
    else       modeQ <= modeD;
  end

  assign active = (modeQ != MODE_IDLE);

  // R5
  oneshot_consumed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ONESHOT && instDone && !accept) |=> modeQ == MODE_IDLE);
  // R6
  sticky_survives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_STICKY && instDone && !accept && !vlSetup) |=> modeQ == MODE_STICKY);
  // R7
  vl_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vlSetup && !accept) |=> modeQ == MODE_IDLE);
  // R8
  setup_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !maskZero) |=> modeQ != MODE_IDLE);
  // R10
  zero_mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && maskZero) |=> modeQ == MODE_IDLE);

endmodule

// File: rtl/remap_datapath.sv
`timescale 1ns/1ps
module remap_datapath
  import remap_cfg_pkg::*;
#(
  parameter int SLOT_CNT = 5,
  parameter int SEL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cfgStrobe_t                strobe,
  input  logic [SLOT_CNT-1:0]       maskIn,
  input  logic [SLOT_CNT*SEL_W-1:0] selIn,
  output logic [SLOT_CNT-1:0]       enOut,
  output logic [SLOT_CNT*SEL_W-1:0] selOut
);
  logic [SLOT_CNT-1:0]       maskQ;
  logic [SLOT_CNT*SEL_W-1:0] selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      selQ  <= '0;
    end else if (strobe.load) begin
      maskQ <= maskIn;
      selQ  <= selIn;
    end else if (strobe.drop) begin
      maskQ <= '0;
      selQ  <= '0;
    end
  end

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_gate
    assign enOut[k] = maskQ[k];
    assign selOut[k*SEL_W +: SEL_W] = maskQ[k] ? selQ[k*SEL_W +: SEL_W] : '0;
  end

  // R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (maskQ == $past(maskIn)) && (selQ == $past(selIn)));
  // R7
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.drop && !strobe.load) |=> (enOut == '0) && (selOut == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.drop) |=> $stable(enOut) && $stable(selOut));

endmodule

// File: rtl/opnd_remap_cfg.sv
`timescale 1ns/1ps
module opnd_remap_cfg
  import remap_cfg_pkg::*;
#(
  parameter logic [5:0] PRIMARY_OPC = 6'd22,
  parameter logic [5:0] EXT_OPC     = 6'd57,
  parameter int SRC_CNT = 3,
  parameter int DST_CNT = 2,
  parameter int SEL_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     setupValid,
  input  logic [31:0]              setupWord,
  input  logic                     instDone,
  input  logic                     vlSetup,
  output logic [SRC_CNT-1:0]       srcEn,
  output logic [SRC_CNT*SEL_W-1:0] srcSel,
  output logic [DST_CNT-1:0]       dstEn,
  output logic [DST_CNT*SEL_W-1:0] dstSel
);
  localparam int SLOT_CNT = SRC_CNT + DST_CNT;

  logic                      accept;
  logic                      persistDec;
  logic [SLOT_CNT-1:0]       maskDec;
  logic [SLOT_CNT*SEL_W-1:0] selDec;
  logic [SLOT_CNT-1:0]       enAll;
  logic [SLOT_CNT*SEL_W-1:0] selAll;
  cfgStrobe_t                strobe;
  logic                      active;

  remap_word_decode #(
    .PRIMARY_OPC(PRIMARY_OPC), .EXT_OPC(EXT_OPC),
    .SLOT_CNT(SLOT_CNT), .SEL_W(SEL_W)
  ) i_decode (
    .word(setupWord), .valid(setupValid), .accept(accept),
    .maskOut(maskDec), .selOut(selDec), .persistOut(persistDec)
  );

  remap_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .accept(accept), .maskZero(maskDec == '0),
    .persistIn(persistDec), .instDone(instDone), .vlSetup(vlSetup),
    .strobe(strobe), .active(active)
  );

  remap_datapath #(.SLOT_CNT(SLOT_CNT), .SEL_W(SEL_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .maskIn(maskDec), .selIn(selDec),
    .enOut(enAll), .selOut(selAll)
  );

  assign srcEn  = enAll[SRC_CNT-1:0];
  assign dstEn  = enAll[SLOT_CNT-1:SRC_CNT];
  assign srcSel = selAll[SRC_CNT*SEL_W-1:0];
  assign dstSel = selAll[SLOT_CNT*SEL_W-1:SRC_CNT*SEL_W];

  // R11 / R5: an idle controller never leaves a slot enabled
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (enAll == '0));
  // R12
  full_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (&maskDec)) |=> (&srcEn) && (&dstEn));
  // R4
  off_slot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enAll == '0) |-> (selAll == '0));

endmodule

// File: tb/test_opnd_remap_cfg.sv
`timescale 1ns/1ps
module test_opnd_remap_cfg;
  localparam logic [5:0] PO = 6'd22;
  localparam logic [5:0] XO = 6'd57;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic [31:0] setupWord = '0;
  logic        instDone = 1'b0;
  logic        vlSetup = 1'b0;
  logic [2:0]  srcEn;
  logic [5:0]  srcSel;
  logic [1:0]  dstEn;
  logic [3:0]  dstSel;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  // Bench model
  logic [4:0] mMask;          // bit4 = first source
  logic [1:0] mSel [5];
  int         mMode;          // 0 idle, 1 one-shot, 2 persistent

  opnd_remap_cfg i_opnd_remap_cfg (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .setupWord(setupWord),
    .instDone(instDone), .vlSetup(vlSetup),
    .srcEn(srcEn), .srcSel(srcSel), .dstEn(dstEn), .dstSel(dstSel)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mkWord(input logic [5:0] po, input logic [4:0] msk,
      input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] s2,
      input logic [1:0] d0, input logic [1:0] d1, input logic pst,
      input logic [3:0] rsv, input logic [5:0] xo);
    return {po, msk, s0, s1, s2, d0, d1, pst, rsv, xo};
  endfunction

  task automatic checkOut(input string tag);
    logic [14:0] exp, act;
    logic [2:0] eSrcEn; logic [5:0] eSrcSel; logic [1:0] eDstEn; logic [3:0] eDstSel;
    eSrcEn = '0; eSrcSel = '0; eDstEn = '0; eDstSel = '0;
    if (mMode != 0) begin
      for (int i = 0; i < 3; i++) begin
        eSrcEn[i] = mMask[4-i];
        eSrcSel[2*i +: 2] = mMask[4-i] ? mSel[i] : 2'd0;
      end
      for (int j = 0; j < 2; j++) begin
        eDstEn[j] = mMask[1-j];
        eDstSel[2*j +: 2] = mMask[1-j] ? mSel[3+j] : 2'd0;
      end
    end
    exp = {eSrcEn, eSrcSel, eDstEn, eDstSel};
    act = {srcEn, srcSel, dstEn, dstSel};
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic v, input logic d,
                       input logic vl, input string tag);
    bit acc;
    @(negedge clk);
    setupWord = w; setupValid = v; instDone = d; vlSetup = vl;
    @(negedge clk);
    setupWord = '0; setupValid = 1'b0; instDone = 1'b0; vlSetup = 1'b0;
    acc = v && (w[31:26] == PO) && (w[5:0] == XO) && (w[9:6] == 4'd0);
    if (acc) begin
      if (w[25:21] == 5'd0) mMode = 0;
      else begin
        mMask = w[25:21];
        mSel[0] = w[20:19]; mSel[1] = w[18:17]; mSel[2] = w[16:15];
        mSel[3] = w[14:13]; mSel[4] = w[12:11];
        mMode = w[10] ? 2 : 1;
      end
    end else if (vl) mMode = 0;
    else if (d && mMode == 1) mMode = 0;
    checkOut(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    mMode = 0; mMask = '0;
    for (int k = 0; k < 5; k++) mSel[k] = 2'd0;
    repeat (3) @(negedge clk);
    checkOut("R11 reset state");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R11 after reset release");

    // Sweep every mask, both persistence settings, rotating selectors
    for (int m = 0; m < 32; m++) begin
      for (int p = 0; p < 2; p++) begin
        logic [1:0] b;
        b = 2'(m + p);
        drive(mkWord(PO, 5'(m), b, b + 2'd1, b + 2'd2, b + 2'd3, b ^ 2'd2, 1'(p), 4'd0, XO),
              1'b1, 1'b0, 1'b0,
              (m == 0) ? "R10 zero mask" : (m == 31) ? "R12 full mask" : "R1 R2 R3 R4 load");
        drive('0, 1'b0, 1'b0, 1'b0, "R5 R6 idle hold");
        drive('0, 1'b0, 1'b1, 1'b0, (p == 1) ? "R6 persistent after done" : "R5 one-shot consumed");
        drive('0, 1'b0, 1'b0, 1'b1, "R7 vl setup clears");
      end
    end

    // Ignored words
    base = mkWord(PO, 5'b10110, 2'd3, 2'd1, 2'd2, 2'd0, 2'd1, 1'b1, 4'd0, XO);
    drive(base, 1'b1, 1'b0, 1'b0, "R1 persistent load");
    for (int r = 0; r < 4; r++)
      drive(mkWord(PO, 5'b11111, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'(1 << r), XO),
            1'b1, 1'b0, 1'b0, "R9 reserved bit set");
    drive(mkWord(PO ^ 6'd1, 5'b01001, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0, 4'd0, XO),
          1'b1, 1'b0, 1'b0, "R9 primary opcode mismatch");
    drive(mkWord(PO, 5'b01001, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0, 4'd0, XO ^ 6'd32),
          1'b1, 1'b0, 1'b0, "R9 extended opcode mismatch");
    drive(mkWord(PO, 5'b01001, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0, 4'd0, XO),
          1'b0, 1'b0, 1'b0, "R9 valid low");
    drive(mkWord(PO, 5'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd2, XO),
          1'b1, 1'b0, 1'b0, "R9 bad zero-mask word ignored");

    // Priority of a new setup
    drive(mkWord(PO, 5'b11000, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 1'b0, 4'd0, XO),
          1'b1, 1'b1, 1'b0, "R8 setup beats done");
    drive(mkWord(PO, 5'b00111, 2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 1'b0, 4'd0, XO),
          1'b1, 1'b0, 1'b1, "R8 setup beats vl");
    drive('0, 1'b0, 1'b1, 1'b0, "R5 done after priority load");
    drive('0, 1'b0, 1'b1, 1'b0, "R5 done while idle");

    // Explicit disable of a persistent configuration
    drive(base, 1'b1, 1'b0, 1'b0, "R6 persistent reload");
    drive(mkWord(PO, 5'd0, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 4'd0, XO),
          1'b1, 1'b1, 1'b0, "R10 zero mask disables");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule